// File: doc/BRIEF.md
# Fault-Injectable Single-Port RAM

This block is a synchronous single-port RAM, addressed by word, that can be made to misbehave on purpose. It is meant as a target for built-in self-test controllers. The bench or the test controller first programs a small table of fault entries. Each entry names one word address, one bit inside that word and a defect kind. It then runs its test sequence against the RAM and checks that the defects are caught. When no entry is enabled, the RAM behaves as an ideal memory.

Each named bit cell follows the rule of its defect kind. There are three families of single-cell defect:

- **Stuck-at:** the cell is pinned to a constant value.
- **Transition:** the cell refuses to rise, or refuses to fall.
- **Write-destructive:** the cell flips when it is written with the value it already holds.

All other cells store and return data normally. Reads take one clock. The fault table can be loaded only while the RAM port is idle.

Top module: `faultram_top`

## Requirements
- R1: A read (`mem_en`=1, `mem_we`=0) returns the stored word on `mem_rdata` one clock later. `mem_rdata` holds its value in every cycle that is not a read. An unfaulted word reads back exactly what was last written to it.
- R2: Kind code 1 (stuck-at-0): the named bit reads 0 whatever was written to it, and the bit is stored as 0.
- R3: Kind code 2 (stuck-at-1): the named bit reads 1 whatever was written to it, including before any write since the fault was loaded.
- R4: Kind code 3 (failed rise): writing 1 into the named bit while it holds 0 leaves it 0. Writing 0 into it, or writing 1 while it holds 1, stores normally.
- R5: Kind code 4 (failed fall): writing 0 into the named bit while it holds 1 leaves it 1. Other writes store normally.
- R6: Kind code 5: writing 0 into the named bit while it holds 0 turns it into 1. A write of 0 over a 1 stores normally.
- R7: Kind code 6: writing 1 into the named bit while it holds 1 turns it into 0. A write of 1 over a 0 stores normally.
- R8: Kind code 0 has no effect, and reserved code 7 has no effect. An entry whose enable is 0 has no effect, whatever kind it holds.
- R9: When two enabled entries name the same bit, the entry with the lower index decides that bit's behaviour.
- R10: A fault-table write (`cfg_we`=1) is ignored in any cycle where `mem_en`=1. The memory access in that cycle still completes, using the old table.
- R11: The table has four independent entries, selected by `cfg_sel`. Entries that name different bits act at the same time.
- R12: After a synchronous active-high reset, `mem_rdata` is 0, every word reads 0, and every fault entry is disabled.
- R13: A March sequence run against the RAM reports no mismatch when no fault is enabled. It reports at least one mismatch for each of the six defect kinds. The sequence is: write 0 ascending; then (read 0, write 0, read 0, write 1) ascending; then (read 1, write 1, read 1, write 0) ascending; then read 0 ascending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Fault-table write strobe, accepted only while `mem_en`=0 |
| cfg_sel | input | 2 | Index of the fault entry to load |
| cfg_en | input | 1 | Enable value for the entry |
| cfg_addr | input | 4 | Word address that the entry targets |
| cfg_bit | input | 3 | Bit index within the word that the entry targets |
| cfg_kind | input | 3 | Defect kind code (0 to 7) |
| mem_en | input | 1 | Memory access request |
| mem_we | input | 1 | 1 = write, 0 = read (when `mem_en`=1) |
| mem_addr | input | 4 | Word address |
| mem_wdata | input | 8 | Write data |
| mem_rdata | output | 8 | Registered read data |

## Verification
A fault-table load and a memory access can arrive in the same cycle. The bench provokes this by raising `cfg_we` together with a read strobe. The stuck-at-0 entry offered in that cycle must be dropped, and the read must still return the stored word. The bench then writes all ones to the targeted word and reads it back. A full word shows that the table was left untouched. It also mixes loads with accesses to the faulted addresses, so that each defect rule is judged against words written just before and just after the entry takes effect.

// File: rtl/faultram_pkg.sv
package faultram_pkg;

    typedef enum logic [2:0] {
        FK_NONE  = 3'd0,
        FK_SA0   = 3'd1,
        FK_SA1   = 3'd2,
        FK_RISE  = 3'd3,
        FK_FALL  = 3'd4,
        FK_WD0   = 3'd5,
        FK_WD1   = 3'd6,
        FK_RSVD  = 3'd7
    } fault_kind_e;

    // Value a cell takes after a write, given its defect kind and old value.
    function automatic logic cell_after_write(fault_kind_e kind, logic old_v, logic new_v);
        logic res;
        unique case (kind)
            FK_SA0:  res = 1'b0;
            FK_SA1:  res = 1'b1;
            FK_RISE: res = (!old_v && new_v)  ? 1'b0 : new_v;
            FK_FALL: res = (old_v && !new_v)  ? 1'b1 : new_v;
            FK_WD0:  res = (!old_v && !new_v) ? 1'b1 : new_v;
            FK_WD1:  res = (old_v && new_v)   ? 1'b0 : new_v;
            default: res = new_v;
        endcase
        return res;
    endfunction

    // Value a cell presents on a read.
    function automatic logic cell_on_read(fault_kind_e kind, logic stored);
        logic res;
        unique case (kind)
            FK_SA0:  res = 1'b0;
            FK_SA1:  res = 1'b1;
            default: res = stored;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/fault_table.sv
module fault_table
    import faultram_pkg::*;
#(
    parameter int NUM_FAULTS = 4,
    parameter int ADDR_W     = 4,
    parameter int BIT_W      = 3,
    localparam int SEL_W     = (NUM_FAULTS > 1) ? $clog2(NUM_FAULTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic                 mem_busy,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic                 cfg_en,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [BIT_W-1:0]     cfg_bit,
    input  logic [2:0]           cfg_kind,
    output logic                 ent_en   [NUM_FAULTS],
    output logic [ADDR_W-1:0]    ent_addr [NUM_FAULTS],
    output logic [BIT_W-1:0]     ent_bit  [NUM_FAULTS],
    output fault_kind_e          ent_kind [NUM_FAULTS]
);

    logic load_ok;
    assign load_ok = cfg_we && !mem_busy;

    for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_en[i]   <= 1'b0;
                ent_addr[i] <= '0;
                ent_bit[i]  <= '0;
                ent_kind[i] <= FK_NONE;
            end else if (load_ok && (cfg_sel == SEL_W'(i))) begin
                ent_en[i]   <= cfg_en;
                ent_addr[i] <= cfg_addr;
                ent_bit[i]  <= cfg_bit;
                ent_kind[i] <= fault_kind_e'(cfg_kind);
            end
        end

        AST_CFG_BLOCKED_BUSY: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && mem_busy) |=> ($stable(ent_en[i]) && $stable(ent_kind[i])
                                      && $stable(ent_addr[i]) && $stable(ent_bit[i]))); // R10

        AST_RESET_CLEARS: assert property (@(posedge clk)
            $past(rst) |-> !ent_en[i]); // R12
    end

endmodule

// File: rtl/fault_lookup.sv
module fault_lookup
    import faultram_pkg::*;
#(
    parameter int NUM_FAULTS = 4,
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int BIT_W      = 3
) (
    input  logic                 ent_en   [NUM_FAULTS],
    input  logic [ADDR_W-1:0]    ent_addr [NUM_FAULTS],
    input  logic [BIT_W-1:0]     ent_bit  [NUM_FAULTS],
    input  fault_kind_e          ent_kind [NUM_FAULTS],
    input  logic [ADDR_W-1:0]    addr,
    output fault_kind_e          bit_kind [DATA_W]
);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        always_comb begin
            bit_kind[b] = FK_NONE;
            // Walk from the highest index down so the lowest matching entry wins.
            for (int k = NUM_FAULTS - 1; k >= 0; k--) begin
                if (ent_en[k] && (ent_addr[k] == addr) && (ent_bit[k] == BIT_W'(b)))
                    bit_kind[b] = ent_kind[k];
            end
        end
    end

endmodule

// File: rtl/faultram_top.sv
module faultram_top
    import faultram_pkg::*;
#(
    parameter int NUM_FAULTS = 4,
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    localparam int DEPTH     = 1 << ADDR_W,
    localparam int BIT_W     = (DATA_W > 1) ? $clog2(DATA_W) : 1,
    localparam int SEL_W     = (NUM_FAULTS > 1) ? $clog2(NUM_FAULTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic                 cfg_en,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [BIT_W-1:0]     cfg_bit,
    input  logic [2:0]           cfg_kind,
    input  logic                 mem_en,
    input  logic                 mem_we,
    input  logic [ADDR_W-1:0]    mem_addr,
    input  logic [DATA_W-1:0]    mem_wdata,
    output logic [DATA_W-1:0]    mem_rdata
);

    logic                ent_en   [NUM_FAULTS];
    logic [ADDR_W-1:0]   ent_addr [NUM_FAULTS];
    logic [BIT_W-1:0]    ent_bit  [NUM_FAULTS];
    fault_kind_e         ent_kind [NUM_FAULTS];
    fault_kind_e         bit_kind [DATA_W];

    logic [DATA_W-1:0]   store [DEPTH];
    logic [DATA_W-1:0]   cur_word;
    logic [DATA_W-1:0]   wr_word;
    logic [DATA_W-1:0]   rd_word;
    logic                do_wr;
    logic                do_rd;

    fault_table #(
        .NUM_FAULTS (NUM_FAULTS),
        .ADDR_W     (ADDR_W),
        .BIT_W      (BIT_W)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .mem_busy (mem_en),
        .cfg_sel  (cfg_sel),
        .cfg_en   (cfg_en),
        .cfg_addr (cfg_addr),
        .cfg_bit  (cfg_bit),
        .cfg_kind (cfg_kind),
        .ent_en   (ent_en),
        .ent_addr (ent_addr),
        .ent_bit  (ent_bit),
        .ent_kind (ent_kind)
    );

    fault_lookup #(
        .NUM_FAULTS (NUM_FAULTS),
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .BIT_W      (BIT_W)
    ) u_lookup (
        .ent_en   (ent_en),
        .ent_addr (ent_addr),
        .ent_bit  (ent_bit),
        .ent_kind (ent_kind),
        .addr     (mem_addr),
        .bit_kind (bit_kind)
    );

    assign do_wr    = mem_en && mem_we;
    assign do_rd    = mem_en && !mem_we;
    assign cur_word = store[mem_addr];

    for (genvar b = 0; b < DATA_W; b++) begin : g_rule
        assign wr_word[b] = cell_after_write(bit_kind[b], cur_word[b], mem_wdata[b]);
        assign rd_word[b] = cell_on_read(bit_kind[b], cur_word[b]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++) store[a] <= '0;
        end else if (do_wr) begin
            store[mem_addr] <= wr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        mem_rdata <= '0;
        else if (do_rd) mem_rdata <= rd_word;
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !do_rd |=> $stable(mem_rdata)); // R1

    for (genvar b = 0; b < DATA_W; b++) begin : g_chk
        AST_SA0_READ: assert property (@(posedge clk) disable iff (rst)
            (do_rd && bit_kind[b] == FK_SA0) |=> !mem_rdata[b]); // R2

        AST_SA1_READ: assert property (@(posedge clk) disable iff (rst)
            (do_rd && bit_kind[b] == FK_SA1) |=> mem_rdata[b]); // R3

        AST_RISE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
            (do_wr && bit_kind[b] == FK_RISE && !cur_word[b] && mem_wdata[b])
            |=> !store[$past(mem_addr)][b]); // R4

        AST_FALL_BLOCKED: assert property (@(posedge clk) disable iff (rst)
            (do_wr && bit_kind[b] == FK_FALL && cur_word[b] && !mem_wdata[b])
            |=> store[$past(mem_addr)][b]); // R5
    end

endmodule

// File: tb/faultram_top_tb.sv
module faultram_top_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [1:0] cfg_sel;
    logic       cfg_en;
    logic [3:0] cfg_addr;
    logic [2:0] cfg_bit;
    logic [2:0] cfg_kind;
    logic       mem_en;
    logic       mem_we;
    logic [3:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    faultram_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_en    (cfg_en),
        .cfg_addr  (cfg_addr),
        .cfg_bit   (cfg_bit),
        .cfg_kind  (cfg_kind),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input logic en, input logic [3:0] a,
                       input logic [2:0] b, input logic [2:0] k);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_en = en; cfg_addr = a; cfg_bit = b; cfg_kind = k;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_faults();
        for (int i = 0; i < 4; i++) cfg(2'(i), 1'b0, 4'd0, 3'd0, 3'd0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        mem_en = 1'b1; mem_we = 1'b1; mem_addr = a; mem_wdata = d;
        @(negedge clk);
        mem_en = 1'b0; mem_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        mem_en = 1'b1; mem_we = 1'b0; mem_addr = a;
        @(negedge clk);
        mem_en = 1'b0;
        d = mem_rdata;
    endtask

    task automatic march(output int mism);
        logic [7:0] d;
        mism = 0;
        for (int a = 0; a < 16; a++) wr(4'(a), 8'h00);
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d); if (d !== 8'h00) mism++;
            wr(4'(a), 8'h00);
            rd(4'(a), d); if (d !== 8'h00) mism++;
            wr(4'(a), 8'hFF);
        end
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d); if (d !== 8'hFF) mism++;
            wr(4'(a), 8'hFF);
            rd(4'(a), d); if (d !== 8'hFF) mism++;
            wr(4'(a), 8'h00);
        end
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d); if (d !== 8'h00) mism++;
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R12 rdata after reset", mem_rdata, 8'h00);
        rd(4'd9, d);
        check("R12 word reads 0 after reset", d, 8'h00);
        wr(4'd6, 8'h5A);                       // would be corrupted by an enabled stuck-at entry
        rd(4'd6, d);
        check("R12 table disabled after reset", d, 8'h5A);
    endtask

    task automatic t_ideal();
        logic [7:0] d;
        wr(4'd1, 8'hA5); wr(4'd2, 8'h3C);
        rd(4'd1, d); check("R1 read word 1", d, 8'hA5);
        rd(4'd2, d); check("R1 read word 2", d, 8'h3C);
        wr(4'd1, 8'h77);
        check("R1 rdata holds across write", mem_rdata, 8'h3C);
        rd(4'd1, d); check("R1 overwrite", d, 8'h77);
    endtask

    task automatic t_stuck();
        logic [7:0] d;
        cfg(2'd0, 1'b1, 4'd3, 3'd2, 3'd1);
        wr(4'd3, 8'hFF); rd(4'd3, d); check("R2 stuck-at-0 bit2", d, 8'hFB);
        clear_faults();
        rd(4'd3, d); check("R2 stored as 0", d, 8'hFB);
        wr(4'd4, 8'h00);
        cfg(2'd1, 1'b1, 4'd4, 3'd7, 3'd2);
        rd(4'd4, d); check("R3 stuck-at-1 before write", d, 8'h80);
        wr(4'd4, 8'h01); rd(4'd4, d); check("R3 stuck-at-1 after write", d, 8'h81);
        clear_faults();
    endtask

    task automatic t_transition();
        logic [7:0] d;
        wr(4'd5, 8'h00);
        cfg(2'd2, 1'b1, 4'd5, 3'd0, 3'd3);
        wr(4'd5, 8'hFF); rd(4'd5, d); check("R4 rise blocked", d, 8'hFE);
        clear_faults();
        wr(4'd5, 8'hFF);
        cfg(2'd2, 1'b1, 4'd5, 3'd0, 3'd3);
        wr(4'd5, 8'hFF); rd(4'd5, d); check("R4 1w1 normal", d, 8'hFF);
        wr(4'd5, 8'h00); rd(4'd5, d); check("R4 fall normal", d, 8'h00);
        cfg(2'd2, 1'b1, 4'd5, 3'd6, 3'd4);
        wr(4'd5, 8'hFF); rd(4'd5, d); check("R5 rise normal", d, 8'hFF);
        wr(4'd5, 8'h00); rd(4'd5, d); check("R5 fall blocked", d, 8'h40);
        clear_faults();
    endtask

    task automatic t_destructive();
        logic [7:0] d;
        wr(4'd7, 8'h00);
        cfg(2'd3, 1'b1, 4'd7, 3'd1, 3'd5);
        wr(4'd7, 8'h00); rd(4'd7, d); check("R6 0w0 flips", d, 8'h02);
        wr(4'd7, 8'h00); rd(4'd7, d); check("R6 1w0 normal", d, 8'h00);
        cfg(2'd3, 1'b1, 4'd7, 3'd1, 3'd6);
        wr(4'd7, 8'hFF); rd(4'd7, d); check("R7 0w1 normal", d, 8'hFF);
        wr(4'd7, 8'hFF); rd(4'd7, d); check("R7 1w1 flips", d, 8'hFD);
        clear_faults();
    endtask

    task automatic t_inert();
        logic [7:0] d;
        cfg(2'd0, 1'b1, 4'd8, 3'd1, 3'd7);
        cfg(2'd1, 1'b0, 4'd8, 3'd3, 3'd1);
        cfg(2'd2, 1'b1, 4'd8, 3'd5, 3'd0);
        wr(4'd8, 8'hFF); rd(4'd8, d); check("R8 reserved/disabled/none inert", d, 8'hFF);
        wr(4'd8, 8'h00); rd(4'd8, d); check("R8 inert on zeros", d, 8'h00);
        clear_faults();
    endtask

    task automatic t_priority_multi();
        logic [7:0] d;
        cfg(2'd0, 1'b1, 4'd9, 3'd2, 3'd1);
        cfg(2'd1, 1'b1, 4'd9, 3'd2, 3'd2);
        wr(4'd9, 8'hFF); rd(4'd9, d); check("R9 lower index wins", d, 8'hFB);
        cfg(2'd0, 1'b0, 4'd9, 3'd2, 3'd1);
        rd(4'd9, d); check("R9 next entry after disable", d, 8'hFF);
        clear_faults();
        cfg(2'd0, 1'b1, 4'd10, 3'd0, 3'd1);
        cfg(2'd1, 1'b1, 4'd10, 3'd7, 3'd2);
        cfg(2'd2, 1'b1, 4'd11, 3'd3, 3'd1);
        cfg(2'd3, 1'b1, 4'd11, 3'd4, 3'd2);
        wr(4'd10, 8'h0F); rd(4'd10, d); check("R11 entries 0,1 together", d, 8'h8E);
        wr(4'd11, 8'h08); rd(4'd11, d); check("R11 entries 2,3 together", d, 8'h10);
        clear_faults();
    endtask

    task automatic t_collision();
        logic [7:0] d;
        wr(4'd12, 8'h66);
        @(negedge clk);
        mem_en = 1'b1; mem_we = 1'b0; mem_addr = 4'd12;
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_en = 1'b1; cfg_addr = 4'd12; cfg_bit = 3'd1; cfg_kind = 3'd1;
        @(negedge clk);
        mem_en = 1'b0; cfg_we = 1'b0;
        check("R10 read completes during cfg", mem_rdata, 8'h66);
        wr(4'd12, 8'hFF); rd(4'd12, d);
        check("R10 cfg ignored while busy", d, 8'hFF);
        clear_faults();
    endtask

    task automatic t_march();
        int m;
        logic [2:0] kinds [6];
        kinds = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6};
        clear_faults();
        march(m); check("R13 fault-free march clean", m, 0);
        for (int i = 0; i < 6; i++) begin
            clear_faults();
            cfg(2'd1, 1'b1, 4'd5, 3'd3, kinds[i]);
            march(m);
            check($sformatf("R13 kind %0d detected", kinds[i]), (m > 0), 1);
        end
        clear_faults();
    endtask

    initial begin
        #800000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_en = 1'b0; cfg_addr = '0;
        cfg_bit = '0; cfg_kind = '0; mem_en = 1'b0; mem_we = 1'b0;
        mem_addr = '0; mem_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ideal();
        t_stuck();
        t_transition();
        t_destructive();
        t_inert();
        t_priority_multi();
        t_collision();
        t_march();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule